// File: doc/BRIEF.md
# Power Control Register with Reset-Type Flag

This block is the 8-bit power control register of a small 8051-class microcontroller. Software reaches it over the internal special-function-register bus with whole-byte reads and writes. The register sends idle-mode and power-down-mode requests to the clock-control logic. It also exports two serial-port mode bits and two spare software flags.

A sticky power-off flag tells a cold start (supply coming up from zero) apart from a warm reset (supply still present). Software can clear the flag after boot. On the next reset it reads the flag to learn which kind of reset occurred. Hardware clears the idle bit when an interrupt wakes the core, and any reset clears both mode bits.

Bus writes, reset inputs and the interrupt-wake input are all sampled on the rising clock edge. Read data is combinational.

Top module: `pwr_ctl_sfr`

## Requirements
- R1: The register responds only at bus address 0x87. A write to any other address leaves it unchanged, and a read of any other address returns 0x00.
- R2: A power-on reset loads the value 0x10. This sets the power-off flag (bit 4) and clears every other bit.
- R3: A warm reset keeps the power-off flag (bit 4) at its previous value and clears bits 7, 6, 3, 2, 1 and 0.
- R4: A bus write sets or clears the power-off flag (bit 4) according to the written data.
- R5: Bit 5 is reserved. It ignores writes and always reads as 0.
- R6: An interrupt-wake pulse clears the idle bit (bit 0). If a write sets bit 0 in the same cycle as the wake, the idle bit still ends up cleared, while the rest of the write takes effect.
- R7: Both reset inputs take priority over a write in the same cycle. A power-on reset also takes priority over a warm reset in the same cycle.
- R8: `pd_req` equals the power-down bit (bit 1). `idle_req` equals the idle bit (bit 0) masked by the power-down bit, so `pd_req` and `idle_req` are never high together.
- R9: `smod_dbl` follows bit 7, `smod_fe` follows bit 6, and `gp_flag[1:0]` follows bits 3 and 2. These bits are plain read/write storage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on (cold) reset, synchronous, active high |
| sys_rst | input | 1 | Warm reset, synchronous, active high |
| wake_irq | input | 1 | Interrupt-wake pulse |
| sfr_addr | input | 8 | SFR bus address |
| sfr_wr | input | 1 | SFR write strobe |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | SFR read data (0 when not addressed) |
| idle_req | output | 1 | Idle-mode request |
| pd_req | output | 1 | Power-down-mode request |
| smod_dbl | output | 1 | Serial double-baud select |
| smod_fe | output | 1 | Serial framing-error view select |
| gp_flag | output | 2 | Software flags {bit 3, bit 2} |

## Verification
A software write can land in the same cycle as an interrupt wake, and it can also land in the same cycle as a reset. The bench provokes both cases by driving the write strobe and the competing input together for one cycle.

When a wake meets a write that sets bit 0, the bench expects the written byte with bit 0 cleared. When a reset meets a write, the bench expects the reset value and none of the written data. In both cases the result is judged by reading the register back through the bus.

// File: rtl/pcr_pkg.sv
package pcr_pkg;
    typedef struct packed {
        logic smod1;
        logic smod0;
        logic rsvd;
        logic pof;
        logic gf1;
        logic gf0;
        logic pd;
        logic idl;
    } pcr_bits_t;

    localparam int PCR_W = $bits(pcr_bits_t);
endpackage

// File: rtl/pcr_decode.sv
module pcr_decode #(
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h87
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    output logic              hit,
    output logic              wr_hit
);
    always_comb begin
        hit    = (addr == REG_ADDR);
        wr_hit = wr && hit;
    end
endmodule

// File: rtl/pcr_core.sv
module pcr_core
    import pcr_pkg::*;
(
    input  logic             clk,
    input  logic             por,
    input  logic             sys_rst,
    input  logic             wake_irq,
    input  logic             wr_hit,
    input  logic [PCR_W-1:0] wdata,
    output pcr_bits_t        st
);
    pcr_bits_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_hit) begin
            st_d = pcr_bits_t'(wdata);
        end
        if (wake_irq) begin
            st_d.idl = 1'b0;
        end
        st_d.rsvd = 1'b0;
        if (sys_rst) begin
            st_d     = '0;
            st_d.pof = st_q.pof;
        end
        if (por) begin
            st_d     = '0;
            st_d.pof = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign st = st_q;

    // R3: a warm reset keeps the power-off flag
    p_warm_keeps_pof_r3: assert property (@(posedge clk) disable iff (por)
        sys_rst |=> (st_q.pof == $past(st_q.pof)));

    // R3: a warm reset clears every other bit
    p_warm_clears_r3: assert property (@(posedge clk) disable iff (por)
        sys_rst |=> ((st_q & 8'hEF) == 8'h00));

    // R6: a wake clears the idle bit, even against a same-cycle write
    p_wake_clears_idl_r6: assert property (@(posedge clk) disable iff (por)
        wake_irq |=> !st_q.idl);

    // R1: without a write, wake or reset, the state holds
    p_hold_r1: assert property (@(posedge clk) disable iff (por)
        (!wr_hit && !wake_irq && !sys_rst) |=> $stable(st_q));
endmodule

// File: rtl/pwr_ctl_sfr.sv
module pwr_ctl_sfr
    import pcr_pkg::*;
#(
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h87
) (
    input  logic              clk,
    input  logic              por,
    input  logic              sys_rst,
    input  logic              wake_irq,
    input  logic [ADDR_W-1:0] sfr_addr,
    input  logic              sfr_wr,
    input  logic [PCR_W-1:0]  sfr_wdata,
    output logic [PCR_W-1:0]  sfr_rdata,
    output logic              idle_req,
    output logic              pd_req,
    output logic              smod_dbl,
    output logic              smod_fe,
    output logic [1:0]        gp_flag
);
    logic      hit, wr_hit;
    pcr_bits_t st;

    pcr_decode #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_dec (
        .addr   (sfr_addr),
        .wr     (sfr_wr),
        .hit    (hit),
        .wr_hit (wr_hit)
    );

    pcr_core u_core (
        .clk      (clk),
        .por      (por),
        .sys_rst  (sys_rst),
        .wake_irq (wake_irq),
        .wr_hit   (wr_hit),
        .wdata    (sfr_wdata),
        .st       (st)
    );

    always_comb begin
        sfr_rdata = hit ? PCR_W'(st) : '0;
        pd_req    = st.pd;
        idle_req  = st.idl && !st.pd;
        smod_dbl  = st.smod1;
        smod_fe   = st.smod0;
        gp_flag   = {st.gf1, st.gf0};
    end

    // R8: the two mode requests are never high together
    p_pd_over_idle_r8: assert property (@(posedge clk) disable iff (por)
        !(pd_req && idle_req));

    // R5: the reserved bit always reads as zero
    p_rsvd_zero_r5: assert property (@(posedge clk) disable iff (por)
        sfr_rdata[5] == 1'b0);

    // R1: a read of another address returns zero
    p_miss_reads_zero_r1: assert property (@(posedge clk) disable iff (por)
        !hit |-> (sfr_rdata == '0));
endmodule

// File: tb/tb_pwr_ctl_sfr.sv
module tb_pwr_ctl_sfr;
    logic       clk = 1'b0;
    logic       por = 1'b1;
    logic       sys_rst = 1'b0;
    logic       wake_irq = 1'b0;
    logic [7:0] sfr_addr = 8'h87;
    logic       sfr_wr = 1'b0;
    logic [7:0] sfr_wdata = 8'h00;
    logic [7:0] sfr_rdata;
    logic       idle_req, pd_req, smod_dbl, smod_fe;
    logic [1:0] gp_flag;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pwr_ctl_sfr dut (
        .clk(clk), .por(por), .sys_rst(sys_rst), .wake_irq(wake_irq),
        .sfr_addr(sfr_addr), .sfr_wr(sfr_wr), .sfr_wdata(sfr_wdata),
        .sfr_rdata(sfr_rdata), .idle_req(idle_req), .pd_req(pd_req),
        .smod_dbl(smod_dbl), .smod_fe(smod_fe), .gp_flag(gp_flag)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // one-cycle bus access with optional same-cycle side inputs
    task automatic cycle(input logic [7:0] a, input logic w, input logic [7:0] d,
                         input logic wk, input logic wr_rst, input logic cold);
        @(negedge clk);
        sfr_addr = a; sfr_wr = w; sfr_wdata = d;
        wake_irq = wk; sys_rst = wr_rst; por = cold;
        @(negedge clk);
        sfr_wr = 1'b0; wake_irq = 1'b0; sys_rst = 1'b0; por = 1'b0;
        sfr_addr = 8'h87;
        #1;
    endtask

    task automatic t_reset;
        cycle(8'h87, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
        check("R2 por value", sfr_rdata, 8'h10);
        check("R8 outputs after por", {6'b0, idle_req, pd_req}, 8'h00);
    endtask

    task automatic t_write_all;
        cycle(8'h87, 1'b1, 8'hFF, 1'b0, 1'b0, 1'b0);
        check("R5 R4 write ff", sfr_rdata, 8'hDF);
        check("R9 side outputs", {4'b0, smod_dbl, smod_fe, gp_flag}, 8'h0F);
        check("R8 pd wins", {6'b0, idle_req, pd_req}, 8'h01);
    endtask

    task automatic t_other_addr;
        cycle(8'h88, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0);
        check("R1 miss write ignored", sfr_rdata, 8'hDF);
        sfr_addr = 8'h88; #1;
        check("R1 miss read zero", sfr_rdata, 8'h00);
        sfr_addr = 8'h87; #1;
    endtask

    task automatic t_idle_wake;
        cycle(8'h87, 1'b1, 8'h01, 1'b0, 1'b0, 1'b0);
        check("R4 pof cleared", sfr_rdata, 8'h01);
        check("R8 idle alone", {6'b0, idle_req, pd_req}, 8'h02);
        cycle(8'h87, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
        check("R6 wake clears idl", sfr_rdata, 8'h00);
        cycle(8'h87, 1'b1, 8'h11, 1'b1, 1'b0, 1'b0);
        check("R6 wake beats write", sfr_rdata, 8'h10);
    endtask

    task automatic t_warm;
        cycle(8'h87, 1'b1, 8'hDF, 1'b0, 1'b0, 1'b0);
        cycle(8'h87, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
        check("R3 warm keeps pof 1", sfr_rdata, 8'h10);
        cycle(8'h87, 1'b1, 8'hCF, 1'b0, 1'b0, 1'b0);
        cycle(8'h87, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
        check("R3 warm keeps pof 0", sfr_rdata, 8'h00);
    endtask

    task automatic t_priority;
        cycle(8'h87, 1'b1, 8'hFF, 1'b0, 1'b1, 1'b0);
        check("R7 warm beats write", sfr_rdata, 8'h00);
        cycle(8'h87, 1'b1, 8'h00, 1'b0, 1'b1, 1'b1);
        check("R7 por beats write and warm", sfr_rdata, 8'h10);
    endtask

    initial begin
        t_reset();
        t_write_all();
        t_other_addr();
        t_idle_wake();
        t_warm();
        t_priority();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule